// File: doc/BRIEF.md
# Multi-Master Hardware Semaphore Bank

A bank of 32 hardware semaphores on a plain 32-bit register bus. Processors share it so that each shared resource has one owner at a time. To take a semaphore, a master writes its 4-bit master identifier to that semaphore's word. The write only takes effect when the semaphore is free. The master then reads the word back. If the low nibble equals its own identifier, the claim succeeded; otherwise another master holds the semaphore. Writing zero returns the semaphore to the free state.

Besides the semaphore words, the bank has a mode register and a pending-flag register. The mode register holds one notify bit. While that bit is set, every release of an owned semaphore raises a pending flag indexed by the identifier of the master that held it. The flags clear when 1s are written to the flag register, and writing 0xFFFF clears them all. With the notify bit clear, the bank is the simple protocol and no flag is ever raised. The bank drives no interrupt lines.

Requests are served one per cycle, in bus order. Read data is registered and appears one cycle after the read request.

Top module: `hsem_bank`

## Requirements
- R1: After reset every semaphore reads 0 (free), the mode register reads 0 and the flag register reads 0.
- R2: A write whose bits [3:0] are nonzero to a free semaphore makes that value the owner. A later read returns the owner in bits [3:0].
- R3: A nonzero write to a semaphore that is already owned is ignored, and the existing owner remains.
- R4: A write whose bits [3:0] are zero to a semaphore frees it, whoever issues it. A free semaphore reads as 0.
- R5: Only write-data bits [3:0] form the master identifier, and bits [31:4] of the write are ignored. Semaphore reads return 0 in bits [31:4].
- R6: Semaphore n (0 to 31) sits at byte address 0x08 + 4*n. Accesses to one semaphore never change another.
- R7: The mode register is at address 0x00. Bit 0 (notify) is writable and reads back, and all other bits read 0.
- R8: The flag register at address 0x90 reads the 16 pending flags in bits [15:0]. When notify is 1, freeing a semaphore owned by identifier k sets flag k. When notify is 0, or the semaphore was already free, no flag changes.
- R9: A write to 0x90 clears each flag whose write-data bit is 1 and leaves the other flags unchanged. Writing 0xFFFF clears every flag.
- R10: Reads of unmapped or misaligned addresses (address bits [1:0] nonzero) return 0. Writes to them change no state.
- R11: Read data appears on rdata one cycle after rd_en is sampled, and shows the state before any write made in the same cycle. rdata is 0 in the cycle after a cycle without rd_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 8 | Byte address of the access |
| wr_en | input | 1 | Write request this cycle |
| wdata | input | 32 | Write data |
| rd_en | input | 1 | Read request this cycle |
| rdata | output | 32 | Registered read data |

## Verification
The assertions assume that reset is held for at least one clock edge before any access, and that address and enables carry defined values whenever reset is low. They assume nothing about which master sends a zero write, because the bank cannot tell masters apart. The stimulus drives every input on the falling clock edge and holds it for a full cycle. It never leaves an input undefined after reset. Random traffic draws identifiers from a small set that includes zero, so claims, refusals and releases all happen often.

// File: rtl/hsem_pkg.sv
package hsem_pkg;
  typedef enum logic [1:0] {
    RGN_NONE = 2'd0,
    RGN_MODE = 2'd1,
    RGN_FLAG = 2'd2,
    RGN_SEM  = 2'd3
  } hsem_rgn_e;
endpackage

// File: rtl/hsem_decode.sv
module hsem_decode
  import hsem_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int NUM_SEM  = 32,
  parameter int SEM_BASE = 8,
  parameter int MODE_OFS = 0,
  parameter int FLAG_OFS = 144,
  localparam int IDX_W   = $clog2(NUM_SEM)
) (
  input  logic [ADDR_W-1:0] addr,
  output hsem_rgn_e         rgn,
  output logic [IDX_W-1:0]  idx
);
  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(SEM_BASE);
  localparam logic [ADDR_W-1:0] END_A  = ADDR_W'(SEM_BASE + 4 * NUM_SEM);
  logic [ADDR_W-1:0] off;

  always_comb begin
    off = addr - BASE_A;
    idx = off[IDX_W+1:2];
    if (addr[1:0] != 2'b00)                  rgn = RGN_NONE;
    else if (addr == ADDR_W'(MODE_OFS))      rgn = RGN_MODE;
    else if (addr == ADDR_W'(FLAG_OFS))      rgn = RGN_FLAG;
    else if (addr >= BASE_A && addr < END_A) rgn = RGN_SEM;
    else                                     rgn = RGN_NONE;
  end
endmodule

// File: rtl/hsem_owners.sv
module hsem_owners #(
  parameter int NUM_SEM = 32,
  parameter int ID_W    = 4,
  localparam int IDX_W  = $clog2(NUM_SEM)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_sem,
  input  logic [IDX_W-1:0] idx,
  input  logic [ID_W-1:0]  wid,
  output logic [ID_W-1:0]  cur_owner,
  output logic             rel_pulse,
  output logic [ID_W-1:0]  rel_id
);
  logic [ID_W-1:0] own_q [NUM_SEM];
  logic [NUM_SEM-1:0] hit;

  genvar g;
  generate
    for (g = 0; g < NUM_SEM; g++) begin : g_hit
      assign hit[g] = wr_sem && (idx == IDX_W'(g));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_SEM; i++) own_q[i] <= '0;
    end else begin
      for (int i = 0; i < NUM_SEM; i++) begin
        if (hit[i]) begin
          if (wid == '0)             own_q[i] <= '0;
          else if (own_q[i] == '0)   own_q[i] <= wid;
        end
      end
    end
  end

  always_comb begin
    cur_owner = own_q[idx];
    rel_id    = own_q[idx];
    rel_pulse = wr_sem && (wid == '0) && (own_q[idx] != '0);
  end

  generate
    for (g = 0; g < NUM_SEM; g++) begin : g_chk
      p_claim_free_r2: assert property (@(posedge clk) disable iff (rst)
        (hit[g] && wid != '0 && own_q[g] == '0) |=> own_q[g] == $past(wid));
      p_keep_owner_r3: assert property (@(posedge clk) disable iff (rst)
        (own_q[g] != '0 && !(hit[g] && wid == '0)) |=> $stable(own_q[g]));
      p_release_r4: assert property (@(posedge clk) disable iff (rst)
        (hit[g] && wid == '0) |=> own_q[g] == '0);
    end
  endgenerate
endmodule

// File: rtl/hsem_bank.sv
module hsem_bank
  import hsem_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int NUM_SEM  = 32,
  parameter int ID_W     = 4,
  parameter int SEM_BASE = 8,
  parameter int MODE_OFS = 0,
  parameter int FLAG_OFS = 144
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rdata
);
  localparam int IDX_W  = $clog2(NUM_SEM);
  localparam int FLAG_W = 1 << ID_W;

  hsem_rgn_e        rgn;
  logic [IDX_W-1:0] idx;
  logic [ID_W-1:0]  cur_owner, rel_id;
  logic             rel_pulse;
  logic             mode_q;
  logic [FLAG_W-1:0] flags_q, flags_d;
  logic [DATA_W-1:0] rd_val, rdata_q;

  hsem_decode #(
    .ADDR_W(ADDR_W), .NUM_SEM(NUM_SEM), .SEM_BASE(SEM_BASE),
    .MODE_OFS(MODE_OFS), .FLAG_OFS(FLAG_OFS)
  ) u_dec (
    .addr(addr), .rgn(rgn), .idx(idx)
  );

  hsem_owners #(.NUM_SEM(NUM_SEM), .ID_W(ID_W)) u_own (
    .clk(clk), .rst(rst),
    .wr_sem(wr_en && rgn == RGN_SEM),
    .idx(idx), .wid(wdata[ID_W-1:0]),
    .cur_owner(cur_owner), .rel_pulse(rel_pulse), .rel_id(rel_id)
  );

  always_comb begin
    flags_d = flags_q;
    if (wr_en && rgn == RGN_FLAG) flags_d = flags_q & ~wdata[FLAG_W-1:0];
    if (mode_q && rel_pulse)      flags_d[rel_id] = 1'b1;
  end

  always_comb begin
    rd_val = '0;
    case (rgn)
      RGN_MODE: rd_val[0] = mode_q;
      RGN_FLAG: rd_val[FLAG_W-1:0] = flags_q;
      RGN_SEM:  rd_val[ID_W-1:0] = cur_owner;
      default:  rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= 1'b0;
      flags_q <= '0;
      rdata_q <= '0;
    end else begin
      if (wr_en && rgn == RGN_MODE) mode_q <= wdata[0];
      flags_q <= flags_d;
      rdata_q <= rd_en ? rd_val : '0;
    end
  end

  assign rdata = rdata_q;

  p_quiet_flags_r8: assert property (@(posedge clk) disable iff (rst)
    (!mode_q) |=> ((flags_q & ~$past(flags_q)) == '0));
  p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rgn == RGN_NONE) |=> rdata == '0);
  p_upper_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rgn == RGN_SEM) |=> rdata[DATA_W-1:ID_W] == '0);
  p_idle_zero_r11: assert property (@(posedge clk) disable iff (rst)
    (!rd_en) |=> rdata == '0);
endmodule

// File: tb/hsem_bank_test.sv
module hsem_bank_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wdata = '0;
  logic        rd_en = 1'b0;
  logic [31:0] rdata;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [3:0]  m_own [32];
  logic        m_mode;
  logic [15:0] m_flags;

  always #(CLK_PERIOD/2) clk = ~clk;

  hsem_bank uut (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en),
    .wdata(wdata), .rd_en(rd_en), .rdata(rdata)
  );

  function automatic logic [7:0] sem_addr(int n);
    return 8'(8 + 4 * n);
  endfunction

  function automatic logic [31:0] exp_read(logic [7:0] a);
    logic [31:0] v = '0;
    if (a[1:0] != 2'b00) return v;
    if (a == 8'h00) v[0] = m_mode;
    else if (a == 8'h90) v[15:0] = m_flags;
    else if (a >= 8'h08 && a < 8'h88) v[3:0] = m_own[(a - 8'h08) >> 2];
    return v;
  endfunction

  function automatic void model_write(logic [7:0] a, logic [31:0] d);
    int n;
    if (a[1:0] != 2'b00) return;
    if (a == 8'h00) m_mode = d[0];
    else if (a == 8'h90) m_flags = m_flags & ~d[15:0];
    else if (a >= 8'h08 && a < 8'h88) begin
      n = (a - 8'h08) >> 2;
      if (d[3:0] == 4'd0) begin
        if (m_own[n] != 4'd0 && m_mode) m_flags[m_own[n]] = 1'b1;
        m_own[n] = 4'd0;
      end else if (m_own[n] == 4'd0) begin
        m_own[n] = d[3:0];
      end
    end
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    model_write(a, d);
  endtask

  task automatic do_read(string req, logic [7:0] a);
    logic [31:0] e;
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    e = exp_read(a);
    @(negedge clk);
    rd_en = 1'b0;
    check(req, rdata, e);
  endtask

  initial begin
    logic [31:0] e;
    int r;
    for (int i = 0; i < 32; i++) m_own[i] = 4'd0;
    m_mode = 1'b0; m_flags = '0;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    for (int i = 0; i < 32; i++) do_read("R1", sem_addr(i));
    do_read("R1", 8'h00);
    do_read("R1", 8'h90);

    // R2 claim, R3 refused claim
    do_write(sem_addr(0), 32'h3);
    do_read("R2", sem_addr(0));
    do_write(sem_addr(0), 32'h5);
    do_read("R3", sem_addr(0));
    do_write(sem_addr(0), 32'h3);
    do_read("R3", sem_addr(0));
    // R5 upper bits ignored
    do_write(sem_addr(31), 32'hABCD_0007);
    do_read("R5", sem_addr(31));
    // R6 independence
    do_write(sem_addr(1), 32'h2);
    do_read("R6", sem_addr(2));
    do_read("R6", sem_addr(1));
    // R4 release by any zero write
    do_write(sem_addr(0), 32'hFFFF_FFF0);
    do_read("R4", sem_addr(0));
    do_write(sem_addr(0), 32'h5);
    do_read("R4", sem_addr(0));
    // R7 mode register
    do_write(8'h00, 32'hFFFF_FFFF);
    do_read("R7", 8'h00);
    // R8 flag on release while notify set
    do_write(sem_addr(4), 32'h9);
    do_write(sem_addr(4), 32'h0);
    do_read("R8", 8'h90);
    do_write(sem_addr(4), 32'h0);
    do_read("R8", 8'h90);
    do_write(sem_addr(1), 32'h0);
    do_read("R8", 8'h90);
    // R9 selective then full clear
    do_write(8'h90, 32'h0000_0200);
    do_read("R9", 8'h90);
    do_write(8'h90, 32'h0000_FFFF);
    do_read("R9", 8'h90);
    // R8 no flags with notify clear
    do_write(8'h00, 32'h0);
    do_write(sem_addr(6), 32'hC);
    do_write(sem_addr(6), 32'h0);
    do_read("R8", 8'h90);
    // R10 unmapped and misaligned
    do_write(sem_addr(3), 32'h4);
    do_write(8'h0D, 32'h0);
    do_read("R10", sem_addr(3));
    do_write(8'h04, 32'h1);
    do_write(8'h88, 32'h1);
    do_read("R10", 8'h04);
    do_read("R10", 8'h88);
    do_read("R10", 8'h0D);
    do_read("R10", 8'h00);
    // R11 read and write in one cycle shows old state
    @(negedge clk);
    addr = sem_addr(3); wdata = 32'h0; wr_en = 1'b1; rd_en = 1'b1;
    e = exp_read(sem_addr(3));
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    model_write(sem_addr(3), 32'h0);
    check("R11", rdata, e);
    @(negedge clk);
    check("R11", rdata, 32'h0);
    do_read("R11", sem_addr(3));

    // random traffic, R2 R3 R4 R8 R9
    for (int k = 0; k < 600; k++) begin
      logic [7:0] a;
      logic [31:0] d;
      r = int'($urandom % 12);
      if (r < 9) a = sem_addr(int'($urandom % 32));
      else if (r == 9) a = 8'h00;
      else if (r == 10) a = 8'h90;
      else a = 8'($urandom);
      d = $urandom;
      if ($urandom % 3 == 0) d[3:0] = 4'd0;
      else d[3:0] = 4'(1 + $urandom % 4);
      if ($urandom % 2 == 0) do_write(a, d);
      do_read("R2", a);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule